// File: doc/BRIEF.md
# Dual-Channel Digital Potentiometer Serial Control Core

This block is the digital heart of a two-channel, 256-step digital potentiometer. A serial host drives a clock, a data line and an active-low chip select. Each frame carries a command byte followed by a data byte. When chip select returns high, the frame either loads a wiper code into one or both channel latches or puts the chosen channels into software shutdown. The serial data output presents the shift register's top bit, so several parts can be chained on one select line.

Two further pins act alongside the serial port. An active-low reset returns every latch to mid-scale. An active-low hardware shutdown opens terminal A and shorts W to B on every channel, and it freezes the applied wiper codes while the latches go on accepting updates. All pins are brought into one system clock domain through two-stage synchronisers. The shift and count logic runs on the detected edges. Each channel presents an 8-bit applied wiper code, a terminal-A-open flag and a B-to-W-short flag.

Top module: `dual_pot_ctrl`

## Requirements
- R1: After power-on reset, both latches and both applied wiper codes are 0x80. Each channel's open and short flags equal the inverse of the hardware shutdown pin, and the serial output is 0.
- R2: A frame is sent MSB first with SDI sampled on SCK rising edges. A command byte with bits [5:4] = 01 writes the data byte into each channel whose select bit is set (bit 0 selects channel 0, bit 1 selects channel 1), and the write ends that channel's software shutdown.
- R3: Command bits [5:4] = 10 put each selected channel into software shutdown, which raises both of its flags. The values 00 and 11 change nothing.
- R4: A command runs on the chip-select rising edge only when the count of SCK rising edges seen while chip select was low is a nonzero multiple of 16. For any other count, the latches and the shutdown state are left as they were.
- R5: When a frame is longer than 16 clocks, only the last 16 bits are decoded. The serial output changes after SCK falling edges and presents the bit that was shifted in 16 clocks earlier.
- R6: The serial output is 0 while chip select is high. It keeps shifting while hardware shutdown is active.
- R7: Holding reset low while chip select is high sets both latches to 0x80. SCK and SDI activity during the reset has no effect.
- R8: While hardware shutdown is low, every channel's open and short flags are 1 and the applied wiper codes hold. Frames still update the latches, and the new codes appear on the wiper outputs when shutdown is released.
- R9: Releasing hardware shutdown ends software shutdown on all channels if a chip-select pulse occurred during the hardware shutdown. Without such a pulse, software shutdown stays as it was.
- R10: A reset pulse during hardware shutdown leaves the applied codes frozen. Both channels then show 0x80 once shutdown is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Chip select, active low |
| rs_n | input | 1 | Latch reset to mid-scale, active low |
| shdn_n | input | 1 | Hardware shutdown, active low |
| sdo | output | 1 | Serial data out for chaining |
| wiper_o | output | NCH*CW (16) | Applied wiper codes, channel 0 in bits [7:0] |
| a_open_o | output | NCH (2) | Terminal A open, one bit per channel |
| bw_short_o | output | NCH (2) | W shorted to B, one bit per channel |

## Verification
Three pairs of functions can fall in the same cycle: a frame that completes during hardware shutdown, a reset during hardware shutdown, and a shutdown release that coincides with the software shutdown cleanup.

The bench sends write frames, a bare chip-select pulse and a reset pulse while the shutdown pin is low, then raises the pin. It judges the result at the ports. The wiper codes and flags must stay frozen during the shutdown. After release, they must show the latch values written, mid-scale, or the cleared software shutdown, as appropriate. The same shutdown window also carries a chained 32-clock frame, so the serial output is checked while shutdown is active.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SHUT  = 2'b10,
    OP_SPARE = 2'b11
  } op_e;

  // operation field of a command byte
  function automatic op_e cmd_op(input logic [BYTE_W-1:0] cmd);
    return op_e'(cmd[5:4]);
  endfunction

  // channel select: low bits of the command byte, one bit per channel
  function automatic logic chan_hit(input logic [BYTE_W-1:0] cmd, input int ch);
    return cmd[ch];
  endfunction

  // frame accepted when at least one clock seen and count wraps to zero
  function automatic logic frame_ok(input logic [CNT_W-1:0] cnt, input logic seen);
    return seen && (cnt == '0);
  endfunction
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dpot_shift.sv
module dpot_shift
  import dpot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_q,
  input  logic               sdi_q,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               cs_fall,
  input  logic               cs_rise,
  output logic               sdo,
  output logic               exec,
  output logic [FRAME_W-1:0] frame
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame  <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (cs_fall) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      sdo_q  <= frame[FRAME_W-1];
    end else if (!cs_q) begin
      if (sck_rise) begin
        frame  <= {frame[FRAME_W-2:0], sdi_q};
        cnt_q  <= cnt_q + 1'b1;
        seen_q <= 1'b1;
      end
      if (sck_fall) begin
        sdo_q <= frame[FRAME_W-1];
      end
    end
  end

  assign exec = cs_rise && frame_ok(cnt_q, seen_q);
  assign sdo  = cs_q ? 1'b0 : sdo_q;
endmodule

// File: rtl/dpot_bank.sv
module dpot_bank
  import dpot_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 8,
  parameter logic [CW-1:0] MID = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rs_act,
  input  logic               shdn_q,
  input  logic               shdn_rise,
  input  logic               cs_rise,
  output logic [NCH*CW-1:0]  latch_bus,
  output logic [NCH*CW-1:0]  wiper_o,
  output logic [NCH-1:0]     a_open_o,
  output logic [NCH-1:0]     bw_short_o
);
  logic [BYTE_W-1:0] cmd;
  logic [CW-1:0]     data;
  op_e               op;
  logic              pulse_seen_q;
  logic              sw_release;

  assign cmd  = frame[FRAME_W-1 -: BYTE_W];
  assign data = frame[CW-1:0];
  assign op   = cmd_op(cmd);

  // chip-select pulse seen during hardware shutdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pulse_seen_q <= 1'b0;
    else if (shdn_rise)      pulse_seen_q <= 1'b0;
    else if (cs_rise && !shdn_q) pulse_seen_q <= 1'b1;
  end

  assign sw_release = shdn_rise && pulse_seen_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] latch_q;
    logic [CW-1:0] app_q;
    logic          sw_q;
    logic          hit;

    assign hit = exec && chan_hit(cmd, c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q <= MID;
        sw_q    <= 1'b0;
      end else begin
        if (rs_act) begin
          latch_q <= MID;
        end else if (hit && op == OP_WRITE) begin
          latch_q <= data;
        end
        if (sw_release) begin
          sw_q <= 1'b0;
        end else if (hit && op == OP_WRITE) begin
          sw_q <= 1'b0;
        end else if (hit && op == OP_SHUT) begin
          sw_q <= 1'b1;
        end
      end
    end

    // applied code tracks the latch except in hardware shutdown
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      app_q <= MID;
      else if (shdn_q) app_q <= latch_q;
    end

    assign latch_bus[c*CW +: CW] = latch_q;
    assign wiper_o[c*CW +: CW]   = app_q;
    assign a_open_o[c]           = !shdn_q || sw_q;
    assign bw_short_o[c]         = !shdn_q || sw_q;
  end
endmodule

// File: rtl/dual_pot_ctrl.sv
module dual_pot_ctrl
  import dpot_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 8,
  parameter logic [CW-1:0] MID = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              rs_n,
  input  logic              shdn_n,
  output logic              sdo,
  output logic [NCH*CW-1:0] wiper_o,
  output logic [NCH-1:0]    a_open_o,
  output logic [NCH-1:0]    bw_short_o
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0]   pins_q;
  logic sck_q, sdi_q, cs_q, rs_q, shdn_q;
  logic sck_d, cs_d, shdn_d;
  logic sck_rise, sck_fall, cs_rise, cs_fall, cs_edge, shdn_rise;
  logic rs_act, exec_pulse;
  logic [FRAME_W-1:0] frame;
  logic [NCH*CW-1:0]  latch_bus;

  dpot_sync #(.W(NSYNC), .RST(5'b11100)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({shdn_n, rs_n, cs_n, sdi, sck}),
    .q   (pins_q)
  );

  assign {shdn_q, rs_q, cs_q, sdi_q, sck_q} = pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      shdn_d <= 1'b1;
    end else begin
      sck_d  <= sck_q;
      cs_d   <= cs_q;
      shdn_d <= shdn_q;
    end
  end

  assign sck_rise  = sck_q && !sck_d;
  assign sck_fall  = !sck_q && sck_d;
  assign cs_rise   = cs_q && !cs_d;
  assign cs_fall   = !cs_q && cs_d;
  assign cs_edge   = cs_rise || cs_fall;
  assign shdn_rise = shdn_q && !shdn_d;
  assign rs_act    = !rs_q && cs_q;

  dpot_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_q     (cs_q),
    .sdi_q    (sdi_q),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sdo      (sdo),
    .exec     (exec_pulse),
    .frame    (frame)
  );

  dpot_bank #(.NCH(NCH), .CW(CW), .MID(MID)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec       (exec_pulse),
    .frame      (frame),
    .rs_act     (rs_act),
    .shdn_q     (shdn_q),
    .shdn_rise  (shdn_rise),
    .cs_rise    (cs_rise),
    .latch_bus  (latch_bus),
    .wiper_o    (wiper_o),
    .a_open_o   (a_open_o),
    .bw_short_o (bw_short_o)
  );
endmodule

// File: rtl/dpot_chk.sv
module dpot_chk #(
  parameter int NCH = 2,
  parameter int CW  = 8,
  parameter logic [CW-1:0] MID = 8'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_q,
  input logic              sck_fall,
  input logic              cs_edge,
  input logic              exec,
  input logic              rs_act,
  input logic [NCH*CW-1:0] latch_bus,
  input logic [NCH*CW-1:0] wiper_o,
  input logic [NCH-1:0]    a_open_o,
  input logic              sdo
);
  assert_flags_in_shdn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_q |-> (&a_open_o));

  assert_wiper_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_q && $past(!shdn_q)) |-> $stable(wiper_o));

  assert_latch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec && !rs_act) |=> $stable(latch_bus));

  assert_reset_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_act |=> (latch_bus == {NCH{MID}}));

  assert_sdo_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> (cs_edge || $stable(sdo)));
endmodule

bind dual_pot_ctrl dpot_chk #(.NCH(NCH), .CW(CW), .MID(MID)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shdn_q    (shdn_q),
  .sck_fall  (sck_fall),
  .cs_edge   (cs_edge),
  .exec      (exec_pulse),
  .rs_act    (rs_act),
  .latch_bus (latch_bus),
  .wiper_o   (wiper_o),
  .a_open_o  (a_open_o),
  .sdo       (sdo)
);

// File: tb/test_dual_pot_ctrl.sv
`timescale 1ns/1ps
module test_dual_pot_ctrl;
  localparam int HP = 6;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, cs_n = 1'b1, rs_n = 1'b1, shdn_n = 1'b1;
  logic sdo;
  logic [15:0] wiper_o;
  logic [1:0]  a_open_o, bw_short_o;
  logic [31:0] cap;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dual_pot_ctrl i_dual_pot_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .rs_n(rs_n), .shdn_n(shdn_n), .sdo(sdo), .wiper_o(wiper_o),
    .a_open_o(a_open_o), .bw_short_o(bw_short_o)
  );

  // {clocks, word sent MSB first, exp ch0, exp ch1, exp sw shutdown {ch1,ch0}}
  localparam logic [55:0] VEC [NV] = '{
    {6'd16, 32'h113C_0000, 8'h3C, 8'h80, 2'b00},
    {6'd16, 32'h12A5_0000, 8'h3C, 8'hA5, 2'b00},
    {6'd16, 32'h1307_0000, 8'h07, 8'h07, 2'b00},
    {6'd15, 32'h11FF_0000, 8'h07, 8'h07, 2'b00},
    {6'd17, 32'h11FF_0000, 8'h07, 8'h07, 2'b00},
    {6'd32, 32'h11EE_1244, 8'h07, 8'h44, 2'b00},
    {6'd16, 32'h2100_0000, 8'h07, 8'h44, 2'b01},
    {6'd16, 32'h0099_0000, 8'h07, 8'h44, 2'b01},
    {6'd16, 32'h3155_0000, 8'h07, 8'h44, 2'b01},
    {6'd16, 32'h1210_0000, 8'h07, 8'h10, 2'b01},
    {6'd16, 32'h1120_0000, 8'h20, 8'h10, 2'b00},
    {6'd16, 32'h2300_0000, 8'h20, 8'h10, 2'b11},
    {6'd0,  32'h0000_0000, 8'h20, 8'h10, 2'b11},
    {6'd16, 32'h1120_0000, 8'h20, 8'h10, 2'b10},
    {6'd16, 32'h1210_0000, 8'h20, 8'h10, 2'b00}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi(input int n, input logic [31:0] w);
    cap = '0;
    cs_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < n; i++) begin
      sdi = w[31-i];
      wait_clk(HP);
      cap = {cap[30:0], sdo};
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    // R1 reset state
    chk("R1", "wipers", {16'h0, wiper_o}, 32'h8080);
    chk("R1", "a_open", {30'h0, a_open_o}, 32'h0);
    chk("R1", "bw_short", {30'h0, bw_short_o}, 32'h0);
    chk("R6", "sdo idle", {31'h0, sdo}, 32'h0);

    // table walk: R2 R3 writes/shutdowns, R4 bad counts, R5 long frame
    for (int k = 0; k < NV; k++) begin
      logic [55:0] v;
      string tag;
      v = VEC[k];
      tag = (v[55:50] == 6'd16) ? "R2 R3" : ((v[55:50] == 6'd32) ? "R5" : "R4");
      spi(int'(v[55:50]), v[49:18]);
      chk(tag, $sformatf("vec%0d ch0", k), {24'h0, wiper_o[7:0]},  {24'h0, v[17:10]});
      chk(tag, $sformatf("vec%0d ch1", k), {24'h0, wiper_o[15:8]}, {24'h0, v[9:2]});
      chk(tag, $sformatf("vec%0d a_open", k), {30'h0, a_open_o}, {30'h0, v[1:0]});
      chk(tag, $sformatf("vec%0d bw_short", k), {30'h0, bw_short_o}, {30'h0, v[1:0]});
    end

    // R8 hardware shutdown
    shdn_n = 1'b0;
    wait_clk(10);
    chk("R8", "flags in shdn", {28'h0, a_open_o, bw_short_o}, 32'hF);
    chk("R8", "wipers held", {16'h0, wiper_o}, 32'h1020);
    spi(16, 32'h1166_0000);
    chk("R8", "write while shdn frozen", {16'h0, wiper_o}, 32'h1020);
    // R5 R6 chained output while shdn low
    spi(32, 32'h5A3C_0000);
    chk("R5 R6", "chained sdo in shdn", {16'h0, cap[15:0]}, 32'h5A3C);
    chk("R6", "sdo low cs high", {31'h0, sdo}, 32'h0);
    shdn_n = 1'b1;
    wait_clk(10);
    chk("R8", "latched value applied", {16'h0, wiper_o}, 32'h1066);
    chk("R8", "flags released", {30'h0, a_open_o}, 32'h0);

    // R9 software shutdown vs shdn release
    spi(16, 32'h2200_0000);
    chk("R3", "sw shdn ch1", {30'h0, a_open_o}, 32'h2);
    shdn_n = 1'b0; wait_clk(10);
    shdn_n = 1'b1; wait_clk(10);
    chk("R9", "kept without cs pulse", {30'h0, a_open_o}, 32'h2);
    shdn_n = 1'b0; wait_clk(10);
    spi(0, 32'h0);
    shdn_n = 1'b1; wait_clk(10);
    chk("R9", "cleared after cs pulse", {30'h0, bw_short_o}, 32'h0);

    // R10 reset during shutdown
    shdn_n = 1'b0; wait_clk(10);
    rs_n = 1'b0; wait_clk(10);
    rs_n = 1'b1; wait_clk(10);
    chk("R10", "frozen during rs", {16'h0, wiper_o}, 32'h1066);
    shdn_n = 1'b1; wait_clk(10);
    chk("R10", "mid after release", {16'h0, wiper_o}, 32'h8080);

    // R7 reset with serial activity
    spi(16, 32'h1101_0000);
    chk("R2", "write before rs", {16'h0, wiper_o}, 32'h8001);
    rs_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; sck = 1'b1; wait_clk(HP);
      sck = 1'b0; wait_clk(HP);
    end
    rs_n = 1'b1;
    wait_clk(12);
    chk("R7", "rs sets mid", {16'h0, wiper_o}, 32'h8080);
    spi(16, 32'h1122_0000);
    chk("R4", "count intact after rs", {16'h0, wiper_o}, 32'h8022);

    // R1 power-up with shdn low
    shdn_n = 1'b0;
    rst_n = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(10);
    chk("R1", "powerup shdn wipers", {16'h0, wiper_o}, 32'h8080);
    chk("R1", "powerup shdn flags", {30'h0, a_open_o}, 32'h3);
    shdn_n = 1'b1;
    wait_clk(10);
    chk("R1", "flags after release", {30'h0, a_open_o}, 32'h0);

    summary();
    $finish;
  end
endmodule